// File: doc/BRIEF.md
# Dual Reloading Down-Counter Timer with Square-Wave Output

This block holds two 16-bit down counters that run side by side and restart themselves. When a counter is at zero and receives a count tick, it loads its own reload value instead of wrapping. Counter 1 takes its reload value from `reload_a`, and counter 2 takes its value from `reload_b`. Each counter therefore repeats every reload+1 ticks. The block serves as a source of periodic interrupts or as a counter of external events.

Each counter has its own tick source, picked by a 2-bit selector:
- a shared programmable prescaler that divides the system clock by 1 to 256;
- rising edges on the external input `evt_b`;
- prescaler ticks that only count while `evt_b` is high, which accumulates pulse width.

When the toggle output is enabled, every underflow of counter 1 inverts `out_a`. This gives a 50% duty-cycle square wave with no software involvement. Each underflow sets a pending flag for its counter. A single interrupt line reports any pending flag whose enable bit is set.

Top module: `dual_reload_timer`

## Requirements
- R1: Counter 1 resets to 0. On each of its ticks it decrements, except at 0, where it loads `reload_a` (an underflow). Its period is therefore `reload_a`+1 ticks.
- R2: Counter 2 behaves the same as counter 1, using `reload_b` as its reload value.
- R3: `out_a` resets to 0. It inverts at the clock edge of each counter 1 underflow while `toggle_en`=1, and holds its level otherwise. With a tick every clock and `reload_a`=3, it changes level every 4 clocks.
- R4: The prescaler produces one tick every `presc_div`+1 system clocks. The first tick after reset falls in the clock cycle that ends at edge `presc_div`+1. Selector value 1 clocks a counter from this tick.
- R5: Selector value 2 clocks a counter from rising edges of `evt_b`. The input passes through a two-stage synchroniser, so the count changes at the third rising clock edge after `evt_b` goes high.
- R6: Selector value 3 clocks a counter from prescaler ticks, but only while the synchronised `evt_b` is high. The input has the same two-edge delay as in R5.
- R7: Selector value 0 stops a counter. The count holds, and `out_a` holds its level.
- R8: A change to a reload input leaves the running count alone. The counter keeps decrementing and only picks up the new value at its next underflow.
- R9: An underflow sets the counter's pending flag (`pend1`, `pend2`) at the same edge. The flag stays set until the matching clear input is high at an edge, and a set in the same cycle wins over a clear. `irq` is registered and equals the OR of (next pending AND enable) over both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_div | input | 8 | Prescaler divisor minus one |
| src_sel1 | input | 2 | Counter 1 tick source: 0 stop, 1 prescaled, 2 event edge, 3 gated prescaled |
| src_sel2 | input | 2 | Counter 2 tick source, same encoding |
| reload_a | input | 16 | Reload value for counter 1 |
| reload_b | input | 16 | Reload value for counter 2 |
| toggle_en | input | 1 | Allows counter 1 underflows to invert `out_a` |
| irq_en1 | input | 1 | Interrupt enable for counter 1 |
| irq_en2 | input | 1 | Interrupt enable for counter 2 |
| pend_clr1 | input | 1 | Clears the counter 1 pending flag |
| pend_clr2 | input | 1 | Clears the counter 2 pending flag |
| evt_b | input | 1 | External event or gate input (asynchronous) |
| out_a | output | 1 | Square-wave output |
| count1 | output | 16 | Current value of counter 1 |
| count2 | output | 16 | Current value of counter 2 |
| pend1 | output | 1 | Counter 1 underflow pending |
| pend2 | output | 1 | Counter 2 underflow pending |
| irq | output | 1 | Combined interrupt request |

## Verification
Random phases pick each counter's tick source, the divisor, the reload values and the enables. During a phase, `evt_b` and the clear inputs change randomly every cycle. A cycle-level model computed from the requirements then exposes wrong reload sources, mixed-up selector codes, mis-timed synchroniser stages and wrong set/clear priority.

Directed patterns cover the cases that random runs hit only rarely:
- a fixed reload of 3 with a tick every clock, which tells a period of reload+1 apart from a period of reload;
- a divisor of 4, which shows the prescaler spacing;
- one `evt_b` rising edge, which pins the two-edge synchroniser delay;
- a low and then high gate, which separates gated counting from free counting;
- a stop code, which must freeze both the count and `out_a`;
- a reload change in mid-count, which must not disturb the running value.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    SRC_STOP      = 2'd0,
    SRC_PRESCALED = 2'd1,
    SRC_EVENT     = 2'd2,
    SRC_GATED     = 2'd3
  } src_e;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;

  // Greater-or-equal keeps the divider safe when div shrinks mid-count
  assign tick = (pcnt >= div);

  always_ff @(posedge clk) begin
    if (rst)       pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0)); // R4
endmodule

// File: rtl/drt_edge_sync.sv
module drt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              level_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign level = sr[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  assign rise = level & ~level_d;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R5
endmodule

// File: rtl/drt_counter.sv
module drt_counter
  import drt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  src_e         src,
  input  logic         pre_tick,
  input  logic         b_rise,
  input  logic         b_level,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         uf
);
  logic tick;

  always_comb begin
    unique case (src)
      SRC_PRESCALED: tick = pre_tick;
      SRC_EVENT:     tick = b_rise;
      SRC_GATED:     tick = pre_tick & b_level;
      default:       tick = 1'b0;
    endcase
  end

  assign uf = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (uf)   cnt <= reload;
    else if (tick) cnt <= cnt - 1'b1;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_STOP) |=> $stable(cnt)); // R7
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R8
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0) |=> (cnt == $past(reload))); // R1
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] presc_div,
  input  logic [1:0]       src_sel1,
  input  logic [1:0]       src_sel2,
  input  logic [CNT_W-1:0] reload_a,
  input  logic [CNT_W-1:0] reload_b,
  input  logic             toggle_en,
  input  logic             irq_en1,
  input  logic             irq_en2,
  input  logic             pend_clr1,
  input  logic             pend_clr2,
  input  logic             evt_b,
  output logic             out_a,
  output logic [CNT_W-1:0] count1,
  output logic [CNT_W-1:0] count2,
  output logic             pend1,
  output logic             pend2,
  output logic             irq
);
  localparam int NCNT = 2;

  logic                       pre_tick;
  logic                       b_level;
  logic                       b_rise;
  src_e                       src_arr [NCNT];
  logic [NCNT-1:0][CNT_W-1:0] rel_arr;
  logic [NCNT-1:0][CNT_W-1:0] cnt_arr;
  logic [NCNT-1:0]            uf;
  logic [NCNT-1:0]            ien;
  logic [NCNT-1:0]            clr;
  logic [NCNT-1:0]            pend;
  logic [NCNT-1:0]            pend_nxt;

  assign src_arr[0] = src_e'(src_sel1);
  assign src_arr[1] = src_e'(src_sel2);
  assign rel_arr    = {reload_b, reload_a};
  assign ien        = {irq_en2, irq_en1};
  assign clr        = {pend_clr2, pend_clr1};

  drt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .div(presc_div), .tick(pre_tick)
  );

  drt_edge_sync #(.STAGES(SYNC_N)) u_bsync (
    .clk(clk), .rst(rst), .din(evt_b), .level(b_level), .rise(b_rise)
  );

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      drt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .src(src_arr[i]), .pre_tick(pre_tick),
        .b_rise(b_rise), .b_level(b_level), .reload(rel_arr[i]),
        .cnt(cnt_arr[i]), .uf(uf[i])
      );
    end
  endgenerate

  // Set has priority over clear
  assign pend_nxt = uf | (pend & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      irq   <= 1'b0;
      out_a <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= |(pend_nxt & ien);
      if (uf[0] && toggle_en) out_a <= ~out_a;
    end
  end

  assign count1 = cnt_arr[0];
  assign count2 = cnt_arr[1];
  assign pend1  = pend[0];
  assign pend2  = pend[1];

  AST_TOGGLE_ON_UF: assert property (@(posedge clk) disable iff (rst)
    (uf[0] && toggle_en) |=> (out_a != $past(out_a))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(uf[0] && toggle_en) |=> $stable(out_a)); // R7
  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    (uf != '0) |=> ((pend & $past(uf)) == $past(uf))); // R9
endmodule

// File: tb/tb_dual_reload_timer.sv
module tb_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  presc_div = '0;
  logic [1:0]  src_sel1 = '0, src_sel2 = '0;
  logic [15:0] reload_a = '0, reload_b = '0;
  logic        toggle_en = 0, irq_en1 = 0, irq_en2 = 0;
  logic        pend_clr1 = 0, pend_clr2 = 0, evt_b = 0;
  logic        out_a, pend1, pend2, irq;
  logic [15:0] count1, count2;

  always #10 clk = ~clk; // 50 MHz

  dual_reload_timer dut (
    .clk(clk), .rst(rst), .presc_div(presc_div), .src_sel1(src_sel1),
    .src_sel2(src_sel2), .reload_a(reload_a), .reload_b(reload_b),
    .toggle_en(toggle_en), .irq_en1(irq_en1), .irq_en2(irq_en2),
    .pend_clr1(pend_clr1), .pend_clr2(pend_clr2), .evt_b(evt_b),
    .out_a(out_a), .count1(count1), .count2(count2),
    .pend1(pend1), .pend2(pend2), .irq(irq)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] c, input logic [15:0] r);
    return (c == 16'd0) ? r : c - 16'd1;
  endfunction

  function automatic bit f_tick(input logic [1:0] s, input bit pt, input bit rise, input bit lvl);
    case (s)
      2'd1:    return pt;
      2'd2:    return rise;
      2'd3:    return pt & lvl;
      default: return 1'b0;
    endcase
  endfunction

  // Reference model from the requirements
  logic [7:0]  m_pc;
  logic        m_b1, m_b2, m_bd, m_out, m_p1, m_p2, m_irq;
  logic [15:0] m_c1, m_c2;
  bit          pt, rs, t1, t2, u1, u2, np1, np2;

  always @(posedge clk) begin
    if (rst) begin
      m_pc <= '0; m_b1 <= 0; m_b2 <= 0; m_bd <= 0;
      m_c1 <= '0; m_c2 <= '0; m_out <= 0; m_p1 <= 0; m_p2 <= 0; m_irq <= 0;
    end else begin
      pt = (m_pc >= presc_div);
      rs = m_b2 & ~m_bd;
      t1 = f_tick(src_sel1, pt, rs, m_b2);
      t2 = f_tick(src_sel2, pt, rs, m_b2);
      u1 = t1 && (m_c1 == 0);
      u2 = t2 && (m_c2 == 0);
      np1 = u1 | (m_p1 & ~pend_clr1);
      np2 = u2 | (m_p2 & ~pend_clr2);
      m_pc <= pt ? 8'd0 : m_pc + 8'd1;
      m_b1 <= evt_b; m_b2 <= m_b1; m_bd <= m_b2;
      if (t1) m_c1 <= step(m_c1, reload_a);
      if (t2) m_c2 <= step(m_c2, reload_b);
      m_p1 <= np1; m_p2 <= np2;
      m_irq <= (np1 & irq_en1) | (np2 & irq_en2);
      if (u1 && toggle_en) m_out <= ~m_out;
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      chk(count1 == m_c1, "R1 count1", count1, m_c1);
      chk(count2 == m_c2, "R2 count2", count2, m_c2);
      chk(out_a == m_out, "R3 out_a", out_a, m_out);
      chk({pend2, pend1, irq} == {m_p2, m_p1, m_irq}, "R9 pend/irq",
          {pend2, pend1, irq}, {m_p2, m_p1, m_irq});
    end
  end

  task automatic summary_and_finish();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary_and_finish();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] c, cb;
    logic        o;
    int          last, gap, seen;
    void'($urandom(32'h5EED_0042));
    wait_n(3);
    rst = 0;
    @(negedge clk);
    // Reset state
    chk(count1 == 0, "R1 reset count1", count1, 0);
    chk(count2 == 0, "R2 reset count2", count2, 0);
    chk(out_a == 0, "R3 reset out_a", out_a, 0);
    chk({pend1, pend2, irq} == 0, "R9 reset flags", {pend1, pend2, irq}, 0);
    cmp_on = 1;

    // R3: square wave, reload 3, tick every clock -> toggle every 4 clocks
    presc_div = 0; reload_a = 3; toggle_en = 1; src_sel1 = 2'd1;
    wait_n(10);
    o = out_a; last = -1; seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_a != o) begin
        if (last >= 0) begin
          gap = i - last;
          chk(gap == 4, "R3 toggle spacing", gap, 4);
          seen++;
        end
        last = i; o = out_a;
      end
    end
    chk(seen >= 5, "R3 toggle count", seen, 5);

    // R4: divisor 4 -> count changes every 5 clocks
    reload_a = 16'd1000; presc_div = 8'd4;
    wait_n(12);
    c = count1; last = -1; seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (count1 != c) begin
        if (last >= 0) begin
          gap = i - last;
          chk(gap == 5, "R4 prescaler spacing", gap, 5);
          seen++;
        end
        last = i; c = count1;
      end
    end
    chk(seen >= 5, "R4 tick count", seen, 5);

    // R7: stop code freezes counts and out_a
    src_sel1 = 2'd0; src_sel2 = 2'd0;
    wait_n(2);
    c = count1; cb = count2; o = out_a;
    wait_n(20);
    chk(count1 == c, "R7 count1 held", count1, c);
    chk(count2 == cb, "R7 count2 held", count2, cb);
    chk(out_a == o, "R7 out_a held", out_a, o);

    // R5: event edge counting, third clock edge after evt_b rises
    evt_b = 0; src_sel1 = 2'd2; reload_a = 16'd500;
    wait_n(5);
    c = count1;
    evt_b = 1;
    wait_n(2);
    chk(count1 == c, "R5 no change before sync", count1, c);
    wait_n(1);
    chk(count1 == step(c, reload_a), "R5 event decrement", count1, step(c, reload_a));
    wait_n(5);
    chk(count1 == step(c, reload_a), "R5 level holds count", count1, step(c, reload_a));

    // R6: gated counting
    evt_b = 0; src_sel1 = 2'd3; presc_div = 0;
    wait_n(4);
    c = count1;
    wait_n(10);
    chk(count1 == c, "R6 gate low holds", count1, c);
    evt_b = 1;
    wait_n(8);
    cb = c;
    for (int k = 0; k < 6; k++) cb = step(cb, reload_a);
    chk(count1 == cb, "R6 gate high counts", count1, cb);
    evt_b = 0;

    // R8: reload change does not disturb running count
    src_sel1 = 2'd1; presc_div = 0; reload_a = 16'd50;
    while (count1 != 0) @(negedge clk);
    wait_n(3);
    c = count1;
    reload_a = 16'd7;
    @(negedge clk);
    chk(count1 == c - 1, "R8 running count kept", count1, c - 1);
    while (count1 != 0) @(negedge clk);
    @(negedge clk);
    chk(count1 == 16'd7, "R8 new reload at underflow", count1, 7);

    // Constrained random phases
    for (int ph = 0; ph < 60; ph++) begin
      src_sel1  = 2'($urandom % 4);
      src_sel2  = 2'($urandom % 4);
      presc_div = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4);
      reload_a  = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 20);
      reload_b  = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 20);
      toggle_en = 1'($urandom);
      irq_en1   = 1'($urandom);
      irq_en2   = 1'($urandom);
      for (int k = 0; k < 200; k++) begin
        if ($urandom % 3 == 0) evt_b = ~evt_b;
        pend_clr1 = ($urandom % 8 == 0);
        pend_clr2 = ($urandom % 8 == 0);
        if (k == 100 && ($urandom % 2 == 0)) reload_a = 16'($urandom % 30);
        @(negedge clk);
      end
    end
    summary_and_finish();
  end
endmodule